// File: doc/BRIEF.md
# Column Truncation Mask Decoder

This block converts a short depth code into a per-column mask for a 32-bit memory word. Each mask bit belongs to one bit column. A mask bit at 1 tells that column to drop its stored value. Truncation always starts at the least significant end, either of the whole word or of each byte. The memory periphery uses the mask directly, so approximate storage can trade precision in the low-order bits for energy.

Two control pins shape the mask. A master enable switches truncation on or off. A granularity pin is active low: when it is low, the code sets a depth inside every byte; when it is high, the code sets a depth across the whole word. The block is pure combinational logic with no storage, so the mask follows its inputs within the same time step.

Top module: `trunc_mask_dec`

## Requirements
- R1: While `trunc_en` is 0, `col_mask` is all zeros for every value of `depth_code` and `lane_mode_n`.
- R2: With `trunc_en`=1 and `lane_mode_n`=1 (word granularity), a code value N sets `col_mask[N-1:0]` to 1 and every higher bit to 0.
- R3: A code of 0 gives an all-zero mask in both granularities while enabled.
- R4: With `trunc_en`=1 and `lane_mode_n`=0 (byte granularity), a value K in `depth_code[2:0]` sets bits [K-1:0] of each byte to 1 and bits [7:K] of each byte to 0. Byte b covers mask bits [8b+7:8b].
- R5: In byte granularity, `depth_code[4:3]` has no effect on the mask.
- R6: In byte granularity, all four bytes of the mask are identical.
- R7: The largest word code, 31, sets bits [30:0] and leaves bit 31 clear, so the most significant column is never truncated.
- R8: The mask is combinational. A change on any input shows on `col_mask` in the same time step, with no clock edge needed and no stale value held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| trunc_en | input | 1 | Master truncation enable, active high |
| lane_mode_n | input | 1 | Granularity select: 0 = per byte, 1 = whole word |
| depth_code | input | 5 | Number of low-order columns to truncate |
| col_mask | output | 32 | Per-column truncation mask, 1 = truncate |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between pins and mask. The bench changes inputs on the falling clock edge and reads `col_mask` one nanosecond later, well before the next rising edge. The clock only paces the stimulus and takes no part in timing the result. For R8, the bench changes inputs twice within one clock phase, with no edge in between, and checks each value after the same short delay.

// File: rtl/trunc_pkg.sv
package trunc_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned CODE_W      = 5;
    localparam int unsigned LANE_W      = 8;
    localparam int unsigned LANES       = WORD_W / LANE_W;
    localparam int unsigned LANE_CODE_W = $clog2(LANE_W);

    // Encoding matches the active-low byte-granularity pin.
    typedef enum logic {
        GRAN_LANE = 1'b0,
        GRAN_WORD = 1'b1
    } gran_e;

    typedef struct packed {
        logic              en;
        gran_e             gran;
        logic [CODE_W-1:0] depth;
    } trunc_req_t;

    function automatic trunc_req_t pack_req(input logic en,
                                            input logic gran_n,
                                            input logic [CODE_W-1:0] depth);
        trunc_req_t r;
        r.en    = en;
        r.gran  = gran_e'(gran_n);
        r.depth = depth;
        return r;
    endfunction

    function automatic logic [LANE_CODE_W-1:0] lane_depth(input logic [CODE_W-1:0] depth);
        return depth[LANE_CODE_W-1:0];
    endfunction

endpackage

// File: rtl/trunc_thermo.sv
module trunc_thermo #(
    parameter int unsigned OUT_W = 32,
    parameter int unsigned IN_W  = 5
) (
    input  logic [IN_W-1:0]  depth,
    output logic [OUT_W-1:0] ones
);

    localparam int unsigned CMP_W = IN_W + 1;

    for (genvar i = 0; i < OUT_W; i++) begin : g_col
        localparam logic [CMP_W-1:0] COL_IDX = CMP_W'(i);
        assign ones[i] = ({1'b0, depth} > COL_IDX);
    end

    // Output is a contiguous run of ones from bit 0 whose length equals depth.
    always_comb begin
        if (!$isunknown(depth)) begin
            p_run_length_r2: assert (int'($countones(ones)) ==
                                     ((int'(depth) > int'(OUT_W)) ? int'(OUT_W) : int'(depth)));
            p_no_hole_r2: assert ((ones & (ones + OUT_W'(1))) == '0);
        end
    end

endmodule

// File: rtl/trunc_lane_rep.sv
module trunc_lane_rep #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4
) (
    input  logic [LANE_W-1:0]       lane,
    output logic [LANE_W*LANES-1:0] word
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign word[b*LANE_W +: LANE_W] = lane;
    end

    always_comb begin
        if (!$isunknown(lane)) begin
            p_rep_count_r6: assert (int'($countones(word)) ==
                                    int'(LANES) * int'($countones(lane)));
            p_top_lane_r6: assert (word[LANE_W*LANES-1 -: LANE_W] == lane);
        end
    end

endmodule

// File: rtl/trunc_mask_dec.sv
module trunc_mask_dec
    import trunc_pkg::*;
(
    input  logic              trunc_en,
    input  logic              lane_mode_n,
    input  logic [CODE_W-1:0] depth_code,
    output logic [WORD_W-1:0] col_mask
);

    trunc_req_t              req;
    logic [WORD_W-1:0]       word_mask;
    logic [LANE_W-1:0]       lane_mask;
    logic [WORD_W-1:0]       lane_word;
    logic [LANE_CODE_W-1:0]  lane_k;

    assign req    = pack_req(trunc_en, lane_mode_n, depth_code);
    assign lane_k = lane_depth(req.depth);

    trunc_thermo #(
        .OUT_W (WORD_W),
        .IN_W  (CODE_W)
    ) u_word_thermo (
        .depth (req.depth),
        .ones  (word_mask)
    );

    trunc_thermo #(
        .OUT_W (LANE_W),
        .IN_W  (LANE_CODE_W)
    ) u_lane_thermo (
        .depth (lane_k),
        .ones  (lane_mask)
    );

    trunc_lane_rep #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_lane_rep (
        .lane (lane_mask),
        .word (lane_word)
    );

    always_comb begin
        col_mask = '0;
        if (req.en) begin
            unique case (req.gran)
                GRAN_WORD: col_mask = word_mask;
                GRAN_LANE: col_mask = lane_word;
                default:   col_mask = '0;
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({trunc_en, lane_mode_n, depth_code})) begin
            p_off_clear_r1: assert (trunc_en || ($countones(col_mask) == 0));
            p_zero_code_r3: assert (!(trunc_en && depth_code == '0) || col_mask == '0);
            p_word_count_r2: assert (!(trunc_en && lane_mode_n) ||
                                     (int'($countones(col_mask)) == int'(depth_code)));
            p_msb_kept_r7: assert (!(trunc_en && lane_mode_n) || !col_mask[WORD_W-1]);
            p_lane_count_r4: assert (!(trunc_en && !lane_mode_n) ||
                                     (int'($countones(col_mask)) ==
                                      int'(LANES) * int'(depth_code[LANE_CODE_W-1:0])));
            p_lane_bit0_r5: assert (!(trunc_en && !lane_mode_n) ||
                                    (col_mask[0] == (depth_code[LANE_CODE_W-1:0] != '0)));
        end
    end

endmodule

// File: tb/sim_trunc_mask_dec.sv
`timescale 1ns/1ps
module sim_trunc_mask_dec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trunc_en = 1'b0;
    logic        lane_mode_n = 1'b1;
    logic [4:0]  depth_code = 5'd0;
    logic [31:0] col_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    trunc_mask_dec u0 (
        .trunc_en    (trunc_en),
        .lane_mode_n (lane_mode_n),
        .depth_code  (depth_code),
        .col_mask    (col_mask)
    );

    function automatic logic [31:0] model(input logic en, input logic gran_n,
                                          input logic [4:0] code);
        logic [31:0] m = '0;
        if (en) begin
            if (gran_n) begin
                for (int i = 0; i < 32; i++) if (i < int'(code)) m[i] = 1'b1;
            end else begin
                for (int b = 0; b < 4; b++)
                    for (int j = 0; j < 8; j++)
                        if (j < int'(code[2:0])) m[b*8+j] = 1'b1;
            end
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (col_mask !== exp) begin
            n_fails++;
            $display("FAIL %s en=%0b gran_n=%0b code=%0d actual=%h expected=%h",
                     req, trunc_en, lane_mode_n, depth_code, col_mask, exp);
        end
    endtask

    task automatic drive(input logic en, input logic gran_n, input logic [4:0] code);
        @(negedge clk);
        trunc_en    = en;
        lane_mode_n = gran_n;
        depth_code  = code;
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 idle", 32'h0);
    endtask

    task automatic t_disabled();
        for (int c = 0; c < 32; c++) begin
            drive(1'b0, c[0], 5'(c));
            check("R1", 32'h0);
        end
    endtask

    task automatic t_word_sweep();
        for (int c = 0; c < 32; c++) begin
            drive(1'b1, 1'b1, 5'(c));
            check(c == 0 ? "R3 word" : "R2", model(1'b1, 1'b1, 5'(c)));
        end
        drive(1'b1, 1'b1, 5'd31);
        check("R7", 32'h7FFF_FFFF);
        drive(1'b1, 1'b1, 5'd8);
        check("R2 eight", 32'h0000_00FF);
    endtask

    task automatic t_lane_sweep();
        for (int c = 0; c < 8; c++) begin
            drive(1'b1, 1'b0, 5'(c));
            check(c == 0 ? "R3 lane" : "R4", model(1'b1, 1'b0, 5'(c)));
        end
        drive(1'b1, 1'b0, 5'd3);
        check("R4 three", 32'h0707_0707);
    endtask

    task automatic t_lane_high_ignored();
        for (int c = 0; c < 8; c++) begin
            for (int h = 1; h < 4; h++) begin
                drive(1'b1, 1'b0, {2'(h), 3'(c)});
                check("R5", model(1'b1, 1'b0, 5'(c)));
            end
        end
        drive(1'b1, 1'b0, 5'd24);
        check("R5 zero low", 32'h0);
    endtask

    task automatic t_lane_repeat();
        drive(1'b1, 1'b0, 5'd7);
        n_checks++;
        if (col_mask[7:0] !== col_mask[15:8] || col_mask[7:0] !== col_mask[23:16] ||
            col_mask[7:0] !== col_mask[31:24] || col_mask[7:0] !== 8'h7F) begin
            n_fails++;
            $display("FAIL R6 actual=%h expected=%h", col_mask, 32'h7F7F_7F7F);
        end
    endtask

    task automatic t_live_change();
        @(negedge clk);
        trunc_en = 1'b1; lane_mode_n = 1'b1; depth_code = 5'd4;
        #0.5;
        check("R8 first", 32'h0000_000F);
        lane_mode_n = 1'b0; depth_code = 5'd2;
        #0.5;
        check("R8 second", 32'h0303_0303);
        trunc_en = 1'b0;
        #0.5;
        check("R8 off", 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_word_sweep();
        t_lane_sweep();
        t_lane_high_ignored();
        t_lane_repeat();
        t_live_change();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule